// File: doc/BRIEF.md
# Serial configuration bitstream streamer

This block is the logic of a serial configuration memory. It shifts a stored bitstream, one bit per configuration clock, into the data input of an SRAM-based programmable device. A bit address counter walks a small ROM that is built when the code is elaborated. Each rising edge of the configuration clock advances the counter, and the next stored bit then appears on the serial data output. The target device samples that output on the same rising edge.

The block runs in one of two modes. In master mode it makes the configuration clock itself by dividing the system clock, and it drives that clock out. In slave mode it is a later device in a chain: it leaves the clock pin undriven and follows the clock that arrives on the clock input. An active-high enable gates everything. The same pin also works as an active-low reset: taking it low clears the address counter and stops clock generation. An active-low chip select lets the counter and the data output run. It does not reset the counter. When the whole bitstream has been sent, a done flag rises and a cascade-select output goes low so the next device in the chain can take over. A parameter sets what the data output does after that point.

All pins are registered and run on one system clock with a synchronous active-high reset. Each bidirectional pin is split into a value output and an output-enable.

Top module: `cfgs_streamer`

## Requirements
- R1: Bits leave in address order starting at address 0. The bit stored at address a is the parity (XOR of all bits) of a AND PAT_MASK. On each rising configuration-clock edge, `sdo_o` holds the bit for the current address, and the address then increments.
- R2: In master mode (`master_i`=1), `cclk_oe_o` is 1. While the block is running, `cclk_o` is a divided clock that stays high for HALF_DIV system cycles and low for HALF_DIV system cycles.
- R3: In slave mode (`master_i`=0), `cclk_oe_o` is 0 and `cclk_o` stays 0. The address advances on rising edges of `cclk_i`, which are resynchronised into the system clock.
- R4: While `cs_n_i` is 1, `sdo_oe_o` is 0 from the next cycle on. The address counter holds, and the master clock stays low. When `cs_n_i` returns to 0, the stream continues with the next unsent bit.
- R5: While `ena_i` is 0, the address resets to 0, `done_o` clears, `cclk_o` is 0 from the next cycle, and `sdo_oe_o` is 0. After re-enabling, the first bit sent is the one at address 0.
- R6: After LEN rising clock edges, `done_o` goes to 1 and stays there while `ena_i` stays 1. `cclk_o` is then 0, and any further clock edges are ignored.
- R7: After completion, POST_DRIVE_HIGH=1 drives `sdo_o`=1 with `sdo_oe_o`=1. POST_DRIVE_HIGH=0 sets `sdo_oe_o` to 0.
- R8: `casc_n_o` is 0 in the cycle after `done_o` is 1, and 1 in the cycle after `done_o` is 0.
- R9: During `rst`, `cclk_o`, `cclk_oe_o`, `sdo_oe_o` and `done_o` are 0, `casc_n_o` is 1, and the address returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| master_i | input | 1 | 1 = generate the configuration clock, 0 = follow `cclk_i` |
| ena_i | input | 1 | High: run; low: clear the address and stop the clock |
| cs_n_i | input | 1 | Active-low chip select |
| cclk_i | input | 1 | Configuration clock from upstream (slave mode) |
| cclk_o | output | 1 | Generated configuration clock value |
| cclk_oe_o | output | 1 | Drive enable for the configuration clock pin |
| sdo_o | output | 1 | Serial data value |
| sdo_oe_o | output | 1 | Drive enable for the serial data pin |
| done_o | output | 1 | All LEN bits have been sent |
| casc_n_o | output | 1 | Active-low select for the next device in the chain |

## Verification
If the address counter is wrong, the error shows at the very next rising configuration-clock edge as a wrong or repeated bit on `sdo_o`. The bench compares every sampled bit against an expected stream held in a queue. A counter that keeps moving while it should hold shows at the first edge after the hold ends, because the stream then skips bits. A done flag that is set too early or too late shows up as bits left in the queue, or as an edge that nothing was expected on. It also changes `cclk_o`, `sdo_oe_o` and `casc_n_o` one cycle later.

// File: rtl/cfgs_pkg.sv
package cfgs_pkg;

  // Gating decoded from the pins for one cycle.
  typedef struct packed {
    logic run;  // enabled, selected and data left
    logic clr;  // enable low: clear the counter
  } cfgs_gate_t;

  // Content of ROM location a: parity of the masked address.
  function automatic logic pat_bit(input int unsigned a, input int unsigned mask);
    return ^(a & mask);
  endfunction

endpackage

// File: rtl/cfgs_clkgen.sv
module cfgs_clkgen #(
  parameter int HALF_DIV    = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic master_i,
  input  logic run_i,
  input  logic cclk_ext_i,
  output logic cclk_gen_o,
  output logic step_o
);
  localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [DW-1:0]        div_q;
  logic                 gen_q;
  logic [SYNC_STAGES:0] sync_q;
  logic                 wrap;
  logic                 ext_rise;

  assign wrap = (div_q == DW'(HALF_DIV - 1));

  // Master divider: toggles every HALF_DIV cycles while running.
  always_ff @(posedge clk) begin
    if (rst || !run_i || !master_i) begin
      div_q <= '0;
      gen_q <= 1'b0;
    end else if (wrap) begin
      div_q <= '0;
      gen_q <= ~gen_q;
    end else begin
      div_q <= div_q + DW'(1);
    end
  end

  // Slave path: resynchronise the upstream clock, last stage kept for edge detect.
  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[SYNC_STAGES-1:0], cclk_ext_i};
  end

  assign ext_rise   = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];
  assign step_o     = run_i & (master_i ? (wrap & ~gen_q) : ext_rise);
  assign cclk_gen_o = gen_q;

endmodule

// File: rtl/cfgs_addr.sv
module cfgs_addr #(
  parameter int LEN = 64,
  parameter int AW  = $clog2(LEN + 1),
  parameter int IW  = $clog2(LEN)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_i,
  input  logic          step_i,
  output logic [IW-1:0] idx_o,
  output logic          done_o
);
  logic [AW-1:0] addr_q;
  logic          done_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      addr_q <= '0;
      done_q <= 1'b0;
    end else if (step_i) begin
      addr_q <= addr_q + AW'(1);
      if (addr_q == AW'(LEN - 1)) done_q <= 1'b1;
    end
  end

  assign idx_o  = addr_q[IW-1:0];
  assign done_o = done_q;

endmodule

// File: rtl/cfgs_rom.sv
module cfgs_rom #(
  parameter int          LEN      = 64,
  parameter int unsigned PAT_MASK = 32'h2D,
  parameter int          IW       = $clog2(LEN)
) (
  input  logic          clk,
  input  logic [IW-1:0] idx_i,
  output logic          bit_o
);
  logic mem [LEN];
  logic rd_q;

  initial begin
    for (int unsigned i = 0; i < LEN; i++) mem[i] = cfgs_pkg::pat_bit(i, PAT_MASK);
  end

  // Registered read so the array maps onto block memory.
  always_ff @(posedge clk) rd_q <= mem[idx_i];

  assign bit_o = rd_q;

endmodule

// File: rtl/cfgs_pins.sv
module cfgs_pins #(
  parameter bit POST_DRIVE_HIGH = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic master_i,
  input  logic ena_i,
  input  logic cs_n_i,
  input  logic done_i,
  input  logic rom_bit_i,
  output logic sdo_o,
  output logic sdo_oe_o,
  output logic cclk_oe_o,
  output logic casc_n_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sdo_o     <= 1'b0;
      sdo_oe_o  <= 1'b0;
      cclk_oe_o <= 1'b0;
      casc_n_o  <= 1'b1;
    end else begin
      sdo_o     <= done_i ? 1'b1 : rom_bit_i;
      sdo_oe_o  <= ena_i & ~cs_n_i & (~done_i | POST_DRIVE_HIGH);
      cclk_oe_o <= master_i;
      casc_n_o  <= ~done_i;
    end
  end

endmodule

// File: rtl/cfgs_streamer.sv
module cfgs_streamer #(
  parameter int          LEN             = 64,
  parameter int          HALF_DIV        = 3,
  parameter int          SYNC_STAGES     = 2,
  parameter int unsigned PAT_MASK        = 32'h2D,
  parameter bit          POST_DRIVE_HIGH = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic master_i,
  input  logic ena_i,
  input  logic cs_n_i,
  input  logic cclk_i,
  output logic cclk_o,
  output logic cclk_oe_o,
  output logic sdo_o,
  output logic sdo_oe_o,
  output logic done_o,
  output logic casc_n_o
);
  import cfgs_pkg::*;

  localparam int AW = $clog2(LEN + 1);
  localparam int IW = $clog2(LEN);

  cfgs_gate_t    gate;
  logic          done;
  logic          step;
  logic [IW-1:0] idx;
  logic          rom_bit;

  always_comb begin
    gate.clr = ~ena_i;
    gate.run = ena_i & ~cs_n_i & ~done;
  end

  cfgs_clkgen #(.HALF_DIV(HALF_DIV), .SYNC_STAGES(SYNC_STAGES)) u_clk (
    .clk(clk), .rst(rst), .master_i(master_i), .run_i(gate.run),
    .cclk_ext_i(cclk_i), .cclk_gen_o(cclk_o), .step_o(step)
  );

  cfgs_addr #(.LEN(LEN), .AW(AW), .IW(IW)) u_addr (
    .clk(clk), .rst(rst), .clr_i(gate.clr), .step_i(step),
    .idx_o(idx), .done_o(done)
  );

  cfgs_rom #(.LEN(LEN), .PAT_MASK(PAT_MASK), .IW(IW)) u_rom (
    .clk(clk), .idx_i(idx), .bit_o(rom_bit)
  );

  cfgs_pins #(.POST_DRIVE_HIGH(POST_DRIVE_HIGH)) u_pins (
    .clk(clk), .rst(rst), .master_i(master_i), .ena_i(ena_i), .cs_n_i(cs_n_i),
    .done_i(done), .rom_bit_i(rom_bit), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o),
    .cclk_oe_o(cclk_oe_o), .casc_n_o(casc_n_o)
  );

  assign done_o = done;

endmodule

// File: rtl/cfgs_chk.sv
module cfgs_chk #(
  parameter bit POST_DRIVE_HIGH = 1'b1
) (
  input logic clk,
  input logic rst,
  input logic master_i,
  input logic ena_i,
  input logic cs_n_i,
  input logic cclk_o,
  input logic cclk_oe_o,
  input logic sdo_oe_o,
  input logic done_o,
  input logic casc_n_o
);
  AST_MASTER_DRIVES: assert property (@(posedge clk) disable iff (rst)
    master_i |=> cclk_oe_o);                                                   // R2
  AST_SLAVE_RELEASES: assert property (@(posedge clk) disable iff (rst)
    !master_i |=> !cclk_oe_o);                                                 // R3
  AST_SLAVE_CLK_LOW: assert property (@(posedge clk) disable iff (rst)
    !master_i && $past(!master_i) |-> !cclk_o);                                // R3
  AST_DESELECT_FLOATS: assert property (@(posedge clk) disable iff (rst)
    cs_n_i |=> !sdo_oe_o);                                                     // R4
  AST_DESELECT_CLK_LOW: assert property (@(posedge clk) disable iff (rst)
    cs_n_i |=> !cclk_o);                                                       // R4
  AST_ENA_LOW_CLEARS: assert property (@(posedge clk) disable iff (rst)
    !ena_i |=> !done_o && !cclk_o && !sdo_oe_o);                               // R5
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    done_o && ena_i |=> done_o);                                               // R6
  AST_DONE_CLK_LOW: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !cclk_o);                                                       // R6
  AST_POST_FLOAT: assert property (@(posedge clk) disable iff (rst)
    (POST_DRIVE_HIGH == 1'b0) && done_o |=> !sdo_oe_o);                        // R7
  AST_CASCADE_LOW: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !casc_n_o);                                                     // R8
  AST_CASCADE_HIGH: assert property (@(posedge clk) disable iff (rst)
    !done_o |=> casc_n_o);                                                     // R8
endmodule

bind cfgs_streamer cfgs_chk #(.POST_DRIVE_HIGH(POST_DRIVE_HIGH)) u_chk (
  .clk(clk), .rst(rst), .master_i(master_i), .ena_i(ena_i), .cs_n_i(cs_n_i),
  .cclk_o(cclk_o), .cclk_oe_o(cclk_oe_o), .sdo_oe_o(sdo_oe_o),
  .done_o(done_o), .casc_n_o(casc_n_o)
);

// File: tb/cfgs_streamer_tb.sv
module cfgs_streamer_tb;
  localparam int          LEN  = 64;
  localparam int          HALF = 3;
  localparam int unsigned MASK = 32'h2D;

  logic clk = 1'b0, rst = 1'b1, master = 1'b1, ena = 1'b0, cs_n = 1'b1, cclk_in = 1'b0;
  logic cclk_o, cclk_oe, sdo, sdo_oe, done, casc_n;
  logic z_cclk_o, z_cclk_oe, z_sdo, z_sdo_oe, z_done, z_casc_n;

  int  n_checks = 0, n_fails = 0;
  bit  exp_q[$];
  logic view_prev = 1'b0, done_prev = 1'b0;

  always #5 clk = ~clk;

  cfgs_streamer #(.LEN(LEN), .HALF_DIV(HALF), .PAT_MASK(MASK), .POST_DRIVE_HIGH(1'b1)) u_dut (
    .clk(clk), .rst(rst), .master_i(master), .ena_i(ena), .cs_n_i(cs_n), .cclk_i(cclk_in),
    .cclk_o(cclk_o), .cclk_oe_o(cclk_oe), .sdo_o(sdo), .sdo_oe_o(sdo_oe),
    .done_o(done), .casc_n_o(casc_n));

  cfgs_streamer #(.LEN(LEN), .HALF_DIV(HALF), .PAT_MASK(MASK), .POST_DRIVE_HIGH(1'b0)) u_dut_z (
    .clk(clk), .rst(rst), .master_i(master), .ena_i(ena), .cs_n_i(cs_n), .cclk_i(cclk_in),
    .cclk_o(z_cclk_o), .cclk_oe_o(z_cclk_oe), .sdo_o(z_sdo), .sdo_oe_o(z_sdo_oe),
    .done_o(z_done), .casc_n_o(z_casc_n));

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit ref_bit(input int a);
    return ($countones(a & MASK) % 2) == 1;
  endfunction

  // Driver side of the scoreboard: the whole expected stream.
  task automatic push_all();
    exp_q.delete();
    for (int a = 0; a < LEN; a++) exp_q.push_back(ref_bit(a));
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic ext_edges(input int n);
    for (int k = 0; k < n; k++) begin
      cclk_in = 1'b1; tick(8);
      cclk_in = 1'b0; tick(8);
    end
  endtask

  // Monitor: at every rising configuration clock edge, compare the data bit.
  always @(negedge clk) begin
    logic view;
    view = master ? cclk_o : cclk_in;
    if (!rst && view && !view_prev && !done_prev && sdo_oe) begin
      if (exp_q.size() == 0) check(1'b0, "R6", "edge with no bit left", int'(sdo), -1);
      else begin
        bit b;
        b = exp_q.pop_front();
        check(sdo === b, "R1", "stream bit", int'(sdo), int'(b));
      end
    end
    view_prev = view;
    done_prev = done;
  end

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "WDOG", "run did not finish", 0, 1);
    summary();
    $finish;
  end

  initial begin
    int cnt;
    int qs;
    tick(4);
    // R9: state held during reset
    check(cclk_o == 0 && cclk_oe == 0 && sdo_oe == 0, "R9", "pins idle in reset",
          int'({cclk_o, cclk_oe, sdo_oe}), 0);
    check(done == 0 && casc_n == 1, "R9", "done/cascade in reset", int'({done, casc_n}), 1);
    rst = 1'b0; cs_n = 1'b0;
    tick(10);
    // R5: enable low keeps clock and data quiet
    check(cclk_o == 0 && sdo_oe == 0, "R5", "enable low idle", int'({cclk_o, sdo_oe}), 0);
    check(cclk_oe == 1, "R2", "master drives clock pin", int'(cclk_oe), 1);

    // Master run
    push_all();
    ena = 1'b1;
    @(negedge clk);
    while (!cclk_o) @(negedge clk);
    cnt = 0;
    while (cclk_o) begin cnt++; @(negedge clk); end
    check(cnt == HALF, "R2", "high phase length", cnt, HALF);
    cnt = 0;
    while (!cclk_o) begin cnt++; @(negedge clk); end
    check(cnt == HALF, "R2", "low phase length", cnt, HALF);

    while (exp_q.size() > LEN - 20) tick(1);
    cs_n = 1'b1;
    tick(3);
    check(sdo_oe == 0 && cclk_o == 0, "R4", "deselected pins", int'({sdo_oe, cclk_o}), 0);
    qs = exp_q.size();
    tick(30);
    check(exp_q.size() == qs, "R4", "counter held while deselected", exp_q.size(), qs);
    cs_n = 1'b0;   // monitor proves the stream resumes at the next bit

    while (exp_q.size() > LEN - 30) tick(1);
    ena = 1'b0;
    tick(3);
    check(cclk_o == 0 && sdo_oe == 0 && done == 0, "R5", "enable dropped mid-run",
          int'({cclk_o, sdo_oe, done}), 0);
    push_all();    // R5: restart must begin at address 0
    tick(2);
    ena = 1'b1;

    while (!done) tick(1);
    tick(4);
    check(exp_q.size() == 0, "R6", "all bits sent", exp_q.size(), 0);
    check(cclk_o == 0, "R6", "clock low after done", int'(cclk_o), 0);
    check(sdo == 1 && sdo_oe == 1, "R7", "post-config driven high", int'({sdo, sdo_oe}), 3);
    check(z_sdo_oe == 0 && z_done == 1, "R7", "post-config released", int'({z_sdo_oe, z_done}), 1);
    check(casc_n == 0, "R8", "cascade select low", int'(casc_n), 0);
    tick(30);
    check(cclk_o == 0 && done == 1, "R6", "stays finished", int'({cclk_o, done}), 1);
    ena = 1'b0;
    tick(3);
    check(done == 0 && casc_n == 1, "R5", "enable low clears done (R8 cascade high)",
          int'({done, casc_n}), 1);

    // Slave run
    master = 1'b0;
    tick(3);
    check(cclk_oe == 0 && cclk_o == 0, "R3", "slave releases clock", int'({cclk_oe, cclk_o}), 0);
    push_all();
    ena = 1'b1;
    tick(4);
    ext_edges(20);
    check(exp_q.size() == LEN - 20, "R3", "slave follows upstream edges", exp_q.size(), LEN - 20);
    cs_n = 1'b1;
    tick(2);
    ext_edges(4);
    check(exp_q.size() == LEN - 20, "R4", "slave edges ignored when deselected", exp_q.size(), LEN - 20);
    check(sdo_oe == 0, "R4", "slave data floats when deselected", int'(sdo_oe), 0);
    cs_n = 1'b0;
    tick(3);
    ext_edges(LEN - 20);
    tick(6);
    check(done == 1 && exp_q.size() == 0, "R6", "slave finished", int'(done), 1);
    ext_edges(4);
    check(sdo == 1 && sdo_oe == 1, "R7", "slave post-config high", int'({sdo, sdo_oe}), 3);
    check(cclk_o == 0 && cclk_oe == 0, "R3", "slave clock pins quiet", int'({cclk_o, cclk_oe}), 0);

    summary();
    $finish;
  end
endmodule